// File: doc/BRIEF.md
# Keypad Code Sequence Detector

This block follows the digits typed on a keypad and raises a single-cycle acceptance pulse when the most recent run of keys equals a stored code. One key entry arrives as a rising edge on a press line, with the key value beside it. The first entry of an attempt wakes the pad. The pad falls back to sleep in three cases: the code is completed, no key arrives for a set number of ticks, or a lockout imposed after too many keys has run out. The tick input is a slow strobe that sets the time base for both timeouts.

Matching does not buffer the key history. Each code position has one enable flag. A new key sets the flag for position i+1 only when the key equals code digit i and flag i was already set. Position 0 is always enabled while the pad is awake, so the detector follows a sliding window over the keys of the current attempt. A key counter limits each attempt. When a press arrives with the counter already at its limit, that press is not evaluated. Instead it starts a lockout that lasts a fixed number of ticks.

Top module: `keypad_code_detector`

## Requirements
- R1: After reset, `code_ok` and `pad_awake` are both low.
- R2: A press while asleep sets `pad_awake` in the cycle after the press edge. That press is also evaluated as the first key of the attempt.
- R3: Code digit i sits at `CODE[i*KEY_W +: KEY_W]`. Digit 0 is the oldest key of the sequence. The default code with four 1-bit digits is 0,1,0,1. When the last NUM_DIGITS evaluated keys of one attempt equal the code, `code_ok` is high for exactly one cycle, the cycle after the completing press edge. In that same cycle `pad_awake` is low.
- R4: A key that breaks the sequence gives no pulse, and the pad stays awake. A later correct run of NUM_DIGITS keys in the same attempt is still accepted (sliding window).
- R5: On every return to sleep, partial match progress and the key counter are discarded. A code split across two attempts is never accepted.
- R6: While awake, IDLE_TICKS ticks with no press between them send the pad to sleep. A press restarts the count. A press and a tick in the same cycle count as a press.
- R7: Each attempt evaluates at most KEY_LIMIT presses. A press that arrives with KEY_LIMIT presses already counted enters lockout. It gives no pulse, even if it would complete the code, and `pad_awake` drops.
- R8: During lockout, presses are ignored: no pulse and no wake-up. Lockout ends on its LOCK_TICKS-th tick, and the next press then wakes the pad.
- R9: A press line held high for several cycles counts as one key. The high level after the first cycle neither wakes the pad nor adds a key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_press | input | 1 | Key entry line; a key is its rising edge |
| key_val | input | KEY_W | Value of the key being entered |
| tick | input | 1 | Time base strobe for idle and lockout timing |
| code_ok | output | 1 | One-cycle pulse when the code is recognised |
| pad_awake | output | 1 | High while an attempt is in progress |

## Verification
The assertions rely on two things. `key_press` and `tick` are low at the first clock edge after reset. `key_val` is stable in every cycle where `key_press` rises. The stimulus meets both conditions: it drives every input on the falling clock edge, it holds each key value for the whole press cycle, and it lowers the press line for at least one cycle between keys, except in the one scenario that holds the line high on purpose. The limit and timeout scenarios use short tick counts so that each boundary sits a few keys or ticks away.

// File: rtl/kcd_pkg.sv
// Package: shared types and default-code helper for the keypad code detector.
// Assumes: total code width (digits * key width) does not exceed 64 bits.
package kcd_pkg;

    // Pad operating states
    typedef enum logic [1:0] {
        PAD_SLEEP = 2'd0,
        PAD_ENTRY = 2'd1,
        PAD_LOCK  = 2'd2
    } pad_state_e;

    // Builds the default code: digit i equals i mod 2, packed digit 0 lowest
    function automatic logic [63:0] alt_code(int unsigned digits, int unsigned kw);
        logic [63:0] r;
        r = '0;
        for (int unsigned i = 0; i < digits; i++) begin
            if ((i % 2) == 1 && (i * kw) < 64) begin
                r[i * kw] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/kcd_press_edge.sv
// Module: turns the raw key entry line into a one-cycle key event on its rising edge.
// Assumes: key_press is already synchronous to clk and debounced.
module kcd_press_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic key_press,
    output logic press_ev
);

    logic press_d;

    // Remember last cycle's level of the entry line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            press_d <= 1'b0;
        end else begin
            press_d <= key_press;
        end
    end

    // Event only on a low-to-high change
    always_comb begin
        press_ev = key_press & ~press_d;
    end

endmodule

// File: rtl/kcd_tick_timer.sv
// Module: counts ticks since the last clear and flags the tick that reaches a terminal value.
// Assumes: the owner clears the counter when expire is acted on or when last changes.
module kcd_tick_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [TW-1:0] last,
    input  logic [TW-1:0] bound,
    output logic          expire
);

    logic [TW-1:0] cnt_q;

    // Tick counter, held at the terminal value until cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != last)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Terminal tick detection
    always_comb begin
        expire = tick & (cnt_q == last);
    end

    // R6
    tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= bound);

endmodule

// File: rtl/kcd_digit_chain.sv
// Module: per-position enable chain that tracks how much of the code the recent keys form.
// Assumes: position 0 is always enabled while the pad is awake; clear wins over step.
module kcd_digit_chain #(
    parameter int                          NUM_DIGITS = 4,
    parameter int                          KEY_W      = 1,
    parameter logic [NUM_DIGITS*KEY_W-1:0] CODE       = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [KEY_W-1:0] key_val,
    output logic             hit
);

    logic [NUM_DIGITS-1:0] dig_eq;

    // Compare the key against every code digit
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_cmp
        always_comb begin
            dig_eq[g] = (key_val == CODE[g*KEY_W +: KEY_W]);
        end
    end

    if (NUM_DIGITS == 1) begin : g_single
        // Single-digit code: any matching key completes it
        always_comb begin
            hit = step & dig_eq[0];
        end
    end else begin : g_chain
        logic [NUM_DIGITS-1:1] en_q;
        logic [NUM_DIGITS-1:0] en_v;
        logic [NUM_DIGITS-1:1] en_n;

        // Effective enables with position 0 permanently on
        always_comb begin
            en_v = {en_q, 1'b1};
        end

        // Next enable for each position from the one below
        for (genvar p = 1; p < NUM_DIGITS; p++) begin : g_next
            always_comb begin
                en_n[p] = dig_eq[p-1] & en_v[p-1];
            end
        end

        // Enable register update per evaluated key
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= '0;
            end else if (clear) begin
                en_q <= '0;
            end else if (step) begin
                en_q <= en_n;
            end
        end

        // Final position reached on this key
        always_comb begin
            hit = step & dig_eq[NUM_DIGITS-1] & en_v[NUM_DIGITS-1];
        end
    end

endmodule

// File: rtl/keypad_code_detector.sv
// Module: top of the keypad code detector: pad state machine, key counter, timers, match chain.
// Assumes: KEY_LIMIT >= 1, IDLE_TICKS >= 1, LOCK_TICKS >= 1, NUM_DIGITS*KEY_W <= 64.
module keypad_code_detector #(
    parameter int                          NUM_DIGITS = 4,
    parameter int                          KEY_W      = 1,
    parameter logic [NUM_DIGITS*KEY_W-1:0] CODE       =
        (NUM_DIGITS*KEY_W)'(kcd_pkg::alt_code(NUM_DIGITS, KEY_W)),
    parameter int                          KEY_LIMIT  = 12,
    parameter int                          IDLE_TICKS = 3,
    parameter int                          LOCK_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_press,
    input  logic [KEY_W-1:0] key_val,
    input  logic             tick,
    output logic             code_ok,
    output logic             pad_awake
);
    import kcd_pkg::*;

    localparam int KCW  = $clog2(KEY_LIMIT + 1);
    localparam int TMAX = (IDLE_TICKS > LOCK_TICKS) ? IDLE_TICKS : LOCK_TICKS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [KCW-1:0] KEY_LIM_V = KCW'(KEY_LIMIT);
    localparam logic [TW-1:0]  IDLE_LAST = TW'(IDLE_TICKS - 1);
    localparam logic [TW-1:0]  LOCK_LAST = TW'(LOCK_TICKS - 1);
    localparam logic [TW-1:0]  TMR_BOUND = TW'(TMAX - 1);

    pad_state_e     state_q, state_n;
    logic [KCW-1:0] key_cnt_q;
    logic           press_ev;
    logic           lock_hit;
    logic           step;
    logic           hit;
    logic           expire;
    logic           tmr_clear;
    logic [TW-1:0]  tmr_last;
    logic           chain_clear;
    logic           accept_q;

    kcd_press_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_press(key_press),
        .press_ev (press_ev)
    );

    // Qualify key events: limit check first, lockout swallows keys
    always_comb begin
        lock_hit = press_ev & (state_q == PAD_ENTRY) & (key_cnt_q == KEY_LIM_V);
        step     = press_ev & (state_q != PAD_LOCK) & ~lock_hit;
    end

    kcd_digit_chain #(
        .NUM_DIGITS(NUM_DIGITS),
        .KEY_W     (KEY_W),
        .CODE      (CODE)
    ) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (chain_clear),
        .step   (step),
        .key_val(key_val),
        .hit    (hit)
    );

    // Pick the timer terminal value for the current state
    always_comb begin
        tmr_last = (state_q == PAD_LOCK) ? LOCK_LAST : IDLE_LAST;
    end

    kcd_tick_timer #(
        .TW(TW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .tick  (tick),
        .last  (tmr_last),
        .bound (TMR_BOUND),
        .expire(expire)
    );

    // Next pad state; key events outrank a same-cycle timeout
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            PAD_SLEEP: begin
                if (step) state_n = hit ? PAD_SLEEP : PAD_ENTRY;
            end
            PAD_ENTRY: begin
                if (lock_hit)    state_n = PAD_LOCK;
                else if (step)   state_n = hit ? PAD_SLEEP : PAD_ENTRY;
                else if (expire) state_n = PAD_SLEEP;
            end
            PAD_LOCK: begin
                if (expire) state_n = PAD_SLEEP;
            end
            default: state_n = PAD_SLEEP;
        endcase
    end

    // Clears for the chain and the timer
    always_comb begin
        chain_clear = (state_n != PAD_ENTRY);
        tmr_clear   = step | (state_n != state_q) | (state_q == PAD_SLEEP);
    end

    // State, key counter and acceptance pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PAD_SLEEP;
            key_cnt_q <= '0;
            accept_q  <= 1'b0;
        end else begin
            state_q  <= state_n;
            accept_q <= step & hit;
            if (state_n != PAD_ENTRY) begin
                key_cnt_q <= '0;
            end else if (step) begin
                key_cnt_q <= key_cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        code_ok   = accept_q;
        pad_awake = (state_q == PAD_ENTRY);
    end

    // R3
    accept_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok |=> !code_ok);

    // R3
    accept_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok |-> !pad_awake);

    // R7
    key_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_cnt_q <= KEY_LIM_V);

    // R8
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAD_LOCK) |-> !code_ok);

    // R2
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_awake) |-> $past(press_ev));

endmodule

// File: tb/tb_keypad_code_detector.sv
module tb_keypad_code_detector;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_press = 1'b0;
    logic [0:0] key_val = 1'b0;
    logic tick = 1'b0;
    logic code_ok;
    logic pad_awake;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keypad_code_detector #(
        .NUM_DIGITS(4),
        .KEY_W     (1),
        .KEY_LIMIT (12),
        .IDLE_TICKS(3),
        .LOCK_TICKS(4)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_press(key_press),
        .key_val  (key_val),
        .tick     (tick),
        .code_ok  (code_ok),
        .pad_awake(pad_awake)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One key: press high for one cycle; returns after the sampling edge
    task automatic press_key(input logic k);
        @(negedge clk);
        key_press = 1'b1;
        key_val   = k;
        @(negedge clk);
        key_press = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 4; i++) pulse_tick();
    endtask

    task automatic t_reset();
        chk("R1", "code_ok after reset", code_ok, 1'b0);
        chk("R1", "pad_awake after reset", pad_awake, 1'b0);
    endtask

    task automatic t_accept();
        press_key(1'b0);
        chk("R2", "awake after first key", pad_awake, 1'b1);
        press_key(1'b1);
        press_key(1'b0);
        chk("R3", "no pulse on prefix", code_ok, 1'b0);
        press_key(1'b1);
        chk("R3", "pulse on completing key", code_ok, 1'b1);
        chk("R3", "asleep with pulse", pad_awake, 1'b0);
        @(negedge clk);
        chk("R3", "pulse lasts one cycle", code_ok, 1'b0);
    endtask

    task automatic t_sliding();
        logic seq[5] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
        for (int i = 0; i < 5; i++) begin
            press_key(seq[i]);
            if (i < 4) chk("R4", "no early pulse", code_ok, 1'b0);
        end
        chk("R4", "sliding window accept", code_ok, 1'b1);
    endtask

    task automatic t_mismatch();
        logic seq[5] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
        logic any = 1'b0;
        for (int i = 0; i < 5; i++) begin
            press_key(seq[i]);
            any |= code_ok;
        end
        chk("R4", "no pulse on broken code", any, 1'b0);
        chk("R4", "still awake after mismatch", pad_awake, 1'b1);
        settle();
    endtask

    task automatic t_split();
        press_key(1'b0);
        press_key(1'b1);
        press_key(1'b0);
        for (int i = 0; i < 3; i++) pulse_tick();
        chk("R5", "asleep after timeout", pad_awake, 1'b0);
        press_key(1'b1);
        chk("R5", "split code not accepted", code_ok, 1'b0);
        chk("R5", "new attempt awake", pad_awake, 1'b1);
        settle();
    endtask

    task automatic t_idle();
        press_key(1'b1);
        pulse_tick();
        pulse_tick();
        chk("R6", "awake before idle limit", pad_awake, 1'b1);
        @(negedge clk);
        key_press = 1'b1;
        key_val   = 1'b1;
        tick      = 1'b1;
        @(negedge clk);
        key_press = 1'b0;
        tick      = 1'b0;
        chk("R6", "press wins over tick", pad_awake, 1'b1);
        pulse_tick();
        pulse_tick();
        chk("R6", "count restarted by press", pad_awake, 1'b1);
        pulse_tick();
        chk("R6", "asleep at idle limit", pad_awake, 1'b0);
    endtask

    task automatic t_limit_accept();
        logic any = 1'b0;
        for (int i = 0; i < 8; i++) begin
            press_key(1'b0);
            any |= code_ok;
        end
        press_key(1'b0);
        press_key(1'b1);
        press_key(1'b0);
        any |= code_ok;
        press_key(1'b1);
        chk("R7", "no pulse before twelfth key", any, 1'b0);
        chk("R7", "twelfth key still evaluated", code_ok, 1'b1);
    endtask

    task automatic t_lockout();
        logic any = 1'b0;
        for (int i = 0; i < 10; i++) press_key(1'b0);
        press_key(1'b1);
        press_key(1'b0);
        chk("R7", "awake at limit", pad_awake, 1'b1);
        press_key(1'b1);
        chk("R7", "over-limit key gives no pulse", code_ok, 1'b0);
        chk("R7", "lockout drops awake", pad_awake, 1'b0);
        press_key(1'b0);
        any |= code_ok | pad_awake;
        press_key(1'b1);
        press_key(1'b0);
        press_key(1'b1);
        any |= code_ok | pad_awake;
        chk("R8", "keys ignored in lockout", any, 1'b0);
        for (int i = 0; i < 3; i++) pulse_tick();
        press_key(1'b0);
        chk("R8", "still locked before last tick", pad_awake, 1'b0);
        pulse_tick();
        press_key(1'b0);
        chk("R8", "wakes after lockout", pad_awake, 1'b1);
        settle();
    endtask

    task automatic t_held();
        press_key(1'b0);
        press_key(1'b1);
        press_key(1'b0);
        @(negedge clk);
        key_press = 1'b1;
        key_val   = 1'b1;
        @(negedge clk);
        chk("R9", "held key accepted once", code_ok, 1'b1);
        @(negedge clk);
        chk("R9", "held level no second pulse", code_ok, 1'b0);
        chk("R9", "held level does not wake", pad_awake, 1'b0);
        @(negedge clk);
        chk("R9", "held level still asleep", pad_awake, 1'b0);
        key_press = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_accept();
        t_sliding();
        t_mismatch();
        t_split();
        t_idle();
        t_limit_accept();
        t_lockout();
        t_held();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nvec++;
            nfail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule